// File: doc/BRIEF.md
# Host-Loaded Transmit Frame Assembler

This block builds an outgoing frame from bytes that a host hands over one at a time. The host first writes the frame length to a length register. It then writes the frame bytes, one per write, to a data register. Each accepted byte goes into an internal frame store at the current write position, and the position then advances. There is no explicit start command. The frame is launched on the write that makes the number of stored bytes equal to the programmed length. At that point the length register and the write position both return to zero.

A launched frame leaves on a byte stream with valid, ready and last. The bytes go out in store order starting at position 0. The last byte carries `m_last`. Back-pressure follows the usual rules: while `m_valid` is high and `m_ready` is low, the data and last flag hold steady and valid stays high. A byte is taken only on a cycle where both valid and ready are high. When the final byte has been taken, a one-cycle `tx_done` pulse follows, and the block accepts host writes again.

The length is validated silently. A value above the maximum frame size loads zero and raises no error. While the length is zero, data writes have nothing to fill and are discarded. The host register path is made of plain pins. The write select and the read select are separate single bits: 0 selects the length register and 1 selects the data register. Reads have no side effects.

Top module: `tx_frame_assembler`

## Requirements
- R1: After reset, `m_valid` and `tx_done` are low and a length read (`host_rsel`=0) returns 0.
- R2: A host write with `host_sel`=0 and a value not above `MAX_LEN` loads that value as the length. A length read returns the loaded value.
- R3: A host write with `host_sel`=0 and a value above `MAX_LEN` loads a length of 0. A length read never returns more than `MAX_LEN`.
- R4: A read with `host_rsel`=1 (data register) always returns 0.
- R5: Data writes (`host_sel`=1) made while the length is 0 are discarded and never launch a frame.
- R6: The frame launches on the data write that brings the stored-byte count to the programmed length. `m_valid` is high in the cycle after that write, and a length read then returns 0.
- R7: Frame bytes appear on `m_data` (bits [DATA_W-1:0] of each data write) in write order starting from the first one. `m_last` is high on the final byte only, and `m_valid` drops after it.
- R8: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` and `m_last` do not change.
- R9: `tx_done` is high for exactly one cycle, the cycle after the handshake of the byte marked last.
- R10: All host writes made while a frame is streaming out are dropped. The length stays 0 and the streaming bytes are unchanged.
- R11: A length write restarts the write position at 0. Bytes written before it do not count toward the new length.
- R12: A length of exactly `MAX_LEN` is accepted, and a full frame of `MAX_LEN` bytes streams out intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one write per cycle |
| host_sel | input | 1 | Write target: 0 length, 1 data |
| host_wdata | input | HOST_W | Write value; low DATA_W bits are the byte for data writes |
| host_rsel | input | 1 | Read target: 0 length, 1 data |
| host_rdata | output | HOST_W | Read value (combinational) |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | DATA_W | Output byte |
| m_last | output | 1 | Final byte of the frame |
| tx_done | output | 1 | One-cycle pulse after the last byte is taken |

## Verification
The bench sweeps every legal length of a small configuration against three ready patterns. This catches an off-by-one launch, which would start streaming one write early or late, and a stream that reorders bytes or raises last on the wrong byte. It loads every length value just past the maximum, where a comparison using the wrong inclusive or exclusive bound would keep a too-large length or refuse the maximum. Writes made during streaming, writes made at zero length and a length rewritten in mid-frame are also exercised. A design that let any of these through would corrupt the outgoing bytes, launch a stray frame, or launch early from a stale write position.

// File: rtl/txa_pkg.sv
package txa_pkg;
  typedef enum logic {
    SEL_LEN  = 1'b0,
    SEL_DATA = 1'b1
  } txa_sel_e;
endpackage

// File: rtl/txa_len_reg.sv
module txa_len_reg #(
  parameter int MAX_LEN = 1514,
  parameter int HOST_W  = 16,
  parameter int CNT_W   = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [HOST_W-1:0] wval,
  input  logic              clear,
  output logic [CNT_W-1:0]  len
);
  localparam logic [HOST_W-1:0] MAX_W = HOST_W'(MAX_LEN);

  logic             in_range;
  logic [CNT_W-1:0] checked;

  // Oversize lengths are silently replaced by zero.
  assign in_range = (wval <= MAX_W);
  assign checked  = in_range ? wval[CNT_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)     len <= '0;
    else if (load)  len <= checked;
    else if (clear) len <= '0;
  end
endmodule

// File: rtl/txa_wr_ctrl.sv
module txa_wr_ctrl #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_len,
  input  logic             data_req,
  input  logic             streaming,
  input  logic [CNT_W-1:0] len,
  output logic [CNT_W-1:0] ptr,
  output logic             store,
  output logic             launch
);
  logic [CNT_W:0] ptr_inc;

  assign ptr_inc = {1'b0, ptr} + (CNT_W+1)'(1);
  // A byte is taken only when a nonzero length is waiting and no frame is leaving.
  assign store   = data_req && !streaming && (len != '0);
  assign launch  = store && (ptr_inc == {1'b0, len});

  always_ff @(posedge clk) begin
    if (!rst_n)                 ptr <= '0;
    else if (load_len || launch) ptr <= '0;
    else if (store)             ptr <= ptr_inc[CNT_W-1:0];
  end
endmodule

// File: rtl/txa_frame_buf.sv
module txa_frame_buf #(
  parameter int DEPTH  = 1514,
  parameter int DATA_W = 8,
  parameter int AW     = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/txa_streamer.sv
module txa_streamer #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [CNT_W-1:0] len,
  input  logic             m_ready,
  output logic             m_valid,
  output logic             m_last,
  output logic [CNT_W-1:0] idx,
  output logic             done
);
  logic             active;
  logic [CNT_W-1:0] flen;
  logic             beat;

  assign m_valid = active;
  assign m_last  = active && (idx == flen - CNT_W'(1));
  assign beat    = active && m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      flen   <= '0;
      idx    <= '0;
      done   <= 1'b0;
    end else begin
      done <= beat && m_last;
      if (launch) begin
        active <= 1'b1;
        flen   <= len;
        idx    <= '0;
      end else if (beat) begin
        if (m_last) active <= 1'b0;
        else        idx    <= idx + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/tx_frame_assembler.sv
module tx_frame_assembler
  import txa_pkg::*;
#(
  parameter int MAX_LEN = 1514,
  parameter int HOST_W  = 16,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_sel,
  input  logic [HOST_W-1:0] host_wdata,
  input  logic              host_rsel,
  output logic [HOST_W-1:0] host_rdata,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_last,
  output logic              tx_done
);
  localparam int CNT_W = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] len;
  logic [CNT_W-1:0] ptr;
  logic [CNT_W-1:0] rd_idx;
  logic             store;
  logic             launch;
  logic             load_len;
  logic             data_req;

  // Host writes of either kind are dropped while a frame is leaving.
  assign load_len = host_wr && (host_sel == SEL_LEN) && !m_valid;
  assign data_req = host_wr && (host_sel == SEL_DATA);

  txa_len_reg #(.MAX_LEN(MAX_LEN), .HOST_W(HOST_W), .CNT_W(CNT_W)) u_len (
    .clk(clk), .rst_n(rst_n), .load(load_len), .wval(host_wdata),
    .clear(launch), .len(len)
  );

  txa_wr_ctrl #(.CNT_W(CNT_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .load_len(load_len), .data_req(data_req),
    .streaming(m_valid), .len(len), .ptr(ptr), .store(store), .launch(launch)
  );

  txa_frame_buf #(.DEPTH(MAX_LEN), .DATA_W(DATA_W), .AW(CNT_W)) u_buf (
    .clk(clk), .we(store), .waddr(ptr), .wdata(host_wdata[DATA_W-1:0]),
    .raddr(rd_idx), .rdata(m_data)
  );

  txa_streamer #(.CNT_W(CNT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .launch(launch), .len(len), .m_ready(m_ready),
    .m_valid(m_valid), .m_last(m_last), .idx(rd_idx), .done(tx_done)
  );

  assign host_rdata = (host_rsel == SEL_LEN) ? HOST_W'(len) : '0;
endmodule

// File: rtl/txa_checker.sv
module txa_checker #(
  parameter int MAX_LEN = 1514,
  parameter int HOST_W  = 16,
  parameter int DATA_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_rsel,
  input logic [HOST_W-1:0] host_rdata,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_data,
  input logic              m_last,
  input logic              tx_done
);
  localparam logic [HOST_W-1:0] MAX_W = HOST_W'(MAX_LEN);

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last))); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done); // R9
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && m_last) |=> tx_done); // R9
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && m_last) |=> !m_valid); // R7
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rsel |-> (host_rdata <= MAX_W)); // R3
  AST_DATA_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    host_rsel |-> (host_rdata == '0)); // R4
  AST_LAUNCH_CLEARS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(m_valid) && !host_rsel) |-> (host_rdata == '0)); // R6
endmodule

bind tx_frame_assembler txa_checker #(
  .MAX_LEN(MAX_LEN), .HOST_W(HOST_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_rsel(host_rsel), .host_rdata(host_rdata),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
  .tx_done(tx_done)
);

// File: tb/sim_tx_frame_assembler.sv
`timescale 1ns/1ps
module sim_tx_frame_assembler;
  localparam int MAXL = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_sel = 1'b0;
  logic [15:0] host_wdata = '0;
  logic        host_rsel = 1'b0;
  logic [15:0] host_rdata;
  logic        m_valid;
  logic        m_ready = 1'b0;
  logic [7:0]  m_data;
  logic        m_last;
  logic        tx_done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [7:0] exp_b [0:15];

  always #5 clk = ~clk;

  tx_frame_assembler #(.MAX_LEN(MAXL), .HOST_W(16), .DATA_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rsel(host_rsel), .host_rdata(host_rdata),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
    .tx_done(tx_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic host_write(input logic sel, input logic [15:0] v);
    @(negedge clk);
    host_wr = 1'b1; host_sel = sel; host_wdata = v;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic read_reg(input logic sel, output int v);
    host_rsel = sel;
    #1;
    v = int'(host_rdata);
    host_rsel = 1'b0;
  endtask

  // Receives a frame of len bytes matching exp_b; ready follows pattern p.
  task automatic rx_frame(input int len, input int p, input string req);
    int idx = 0;
    int cyc = 0;
    while (idx < len && cyc < 200) begin
      m_ready = (p == 0) ? 1'b1 : (p == 1) ? logic'(cyc % 2) : logic'(cyc % 3 == 2);
      #1;
      if (!m_valid) begin
        chk(1'b0, req, "valid during frame", 0, 1);
        idx = len;
      end else if (m_ready) begin
        chk(m_data == exp_b[idx], "R7", "byte value", int'(m_data), int'(exp_b[idx]));
        chk(m_last == (idx == len - 1), "R7", "last flag", int'(m_last), int'(idx == len - 1));
        idx++;
      end
      @(negedge clk);
      cyc++;
    end
    m_ready = 1'b0;
    chk(tx_done == 1'b1, "R9", "done after last", int'(tx_done), 1);
    chk(m_valid == 1'b0, "R7", "valid after last", int'(m_valid), 0);
    @(negedge clk);
    chk(tx_done == 1'b0, "R9", "done one cycle", int'(tx_done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    read_reg(1'b0, v);
    chk(v == 0, "R1", "length after reset", v, 0);
    chk(m_valid == 1'b0, "R1", "valid after reset", int'(m_valid), 0);
    chk(tx_done == 1'b0, "R1", "done after reset", int'(tx_done), 0);

    // R2 / R12 sweep of every legal length with three ready patterns
    for (int len = 1; len <= MAXL; len++) begin
      for (int p = 0; p < 3; p++) begin
        host_write(1'b0, 16'(len));
        read_reg(1'b0, v);
        chk(v == len, (len == MAXL) ? "R12" : "R2", "length readback", v, len);
        for (int i = 0; i < len; i++) begin
          exp_b[i] = 8'(len * 16 + i * 3 + p * 7 + 1);
          chk(m_valid == 1'b0, "R6", "no early launch", int'(m_valid), 0);
          host_write(1'b1, {8'h5A, exp_b[i]});
        end
        chk(m_valid == 1'b1, "R6", "launch after final write", int'(m_valid), 1);
        read_reg(1'b0, v);
        chk(v == 0, "R6", "length cleared at launch", v, 0);
        read_reg(1'b1, v);
        chk(v == 0, "R4", "data read", v, 0);
        rx_frame(len, p, (len == MAXL) ? "R12" : "R7");
      end
    end

    // R3 oversize lengths load zero
    for (int x = MAXL + 1; x <= MAXL + 12; x++) begin
      host_write(1'b0, 16'(3));
      host_write(1'b0, 16'(x));
      read_reg(1'b0, v);
      chk(v == 0, "R3", "oversize length", v, 0);
    end
    host_write(1'b0, 16'hFFFF);
    read_reg(1'b0, v);
    chk(v == 0, "R3", "all-ones length", v, 0);

    // R5 data writes at zero length
    for (int i = 0; i < 20; i++) begin
      host_write(1'b1, 16'(i));
      chk(m_valid == 1'b0, "R5", "no launch at zero length", int'(m_valid), 0);
    end
    host_write(1'b0, 16'(1));
    exp_b[0] = 8'hAB;
    host_write(1'b1, 16'h00AB);
    chk(m_valid == 1'b1, "R5", "single byte frame", int'(m_valid), 1);
    rx_frame(1, 0, "R5");

    // R10 writes during streaming are dropped
    host_write(1'b0, 16'(3));
    for (int i = 0; i < 3; i++) begin
      exp_b[i] = 8'(8'hC0 + i);
      host_write(1'b1, 16'(8'hC0 + i));
    end
    host_write(1'b0, 16'(5));
    host_write(1'b1, 16'h0011);
    host_write(1'b1, 16'h0022);
    read_reg(1'b0, v);
    chk(v == 0, "R10", "length write dropped", v, 0);
    chk(m_valid == 1'b1, "R10", "still streaming", int'(m_valid), 1);
    rx_frame(3, 1, "R10");
    read_reg(1'b0, v);
    chk(v == 0, "R10", "length after frame", v, 0);

    // R11 length rewrite restarts the write position
    host_write(1'b0, 16'(4));
    host_write(1'b1, 16'h0077);
    host_write(1'b1, 16'h0078);
    host_write(1'b0, 16'(3));
    for (int i = 0; i < 3; i++) begin
      exp_b[i] = 8'(8'h30 + i);
      chk(m_valid == 1'b0, "R11", "no launch from stale position", int'(m_valid), 0);
      host_write(1'b1, 16'(8'h30 + i));
    end
    chk(m_valid == 1'b1, "R11", "launch after new length", int'(m_valid), 1);
    rx_frame(3, 2, "R11");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule